// File: doc/BRIEF.md
# Sensor Hub User Control Register

This block is the user control register of a sensor hub. Software writes an 8-bit word through a simple synchronous write port and reads the register back through a combinational read port. Two bits are persistent modes. One selects SPI mode for the host interface. The other enables an on-chip I2C master, which isolates the auxiliary sensor bus from the host lines. When the master is disabled, the auxiliary bus is a straight pass-through of the host data and clock lines.

Two further bits are one-shot reset commands. Writing a 1 to either of them launches a strobe that clears itself. The sample-FIFO strobe rises as soon as the write is presented, before any clock edge. It is released on the clock edge that follows the write edge. The signal-path strobe is fully synchronous and lasts one cycle after the write edge. The FIFO and the signal-path logic are outside this block; only their reset strobes leave it.

Each strobe is driven by its own small state machine with two states, IDLE and PULSE. The transition IDLE to PULSE (start) is taken on a write with the strobe bit set. PULSE to PULSE (hold or restart) is taken while the pulse counter has not reached its limit, or when a new write with the bit set arrives. PULSE to IDLE (done) is taken when the counter reaches its limit and no new write is present.

Top module: `hub_ctrl_reg`

## Requirements
- R1: While rst_n is low, and after it is released, rd_data reads 0x00. spi_mode_o, aux_mst_en_o, fifo_rst_o and path_rst_o are all 0.
- R2: When bit 5 of the register (value 0x20) is 1, aux_mst_en_o is 1 and aux_sda_o and aux_scl_o are both held at 1, whatever the host lines do.
- R3: When bit 5 is 0, aux_sda_o equals host_sda_i and aux_scl_o equals host_scl_i, combinationally.
- R4: Bit 4 (value 0x10) is stored on a write and drives spi_mode_o. It reads back at bit 4.
- R5: In the cycle in which wr_en is 1 and wr_data bit 2 (0x04) is 1, fifo_rst_o is 1 before the clock edge that takes the write.
- R6: After that edge, fifo_rst_o stays 1 and rd_data bit 2 reads 1 for exactly one cycle. Both return to 0 at the next edge.
- R7: A write with wr_data bit 0 (0x01) set makes path_rst_o 1 and rd_data bit 0 read 1 for exactly the one cycle after the write edge. path_rst_o is 0 during the write cycle itself.
- R8: Bits 7, 6, 3 and 1 (mask 0xCA) always read 0. Writing 1s to them changes no output.
- R9: Writing 0 to bit 2 or bit 0 starts no strobe. A new write with a strobe bit set while that strobe is active restarts it, extending it by one cycle.
- R10: While wr_en is 0, bits 5 and 4 keep their value regardless of wr_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Register read-back |
| host_sda_i | input | 1 | Host-side I2C data line |
| host_scl_i | input | 1 | Host-side I2C clock line |
| aux_sda_o | output | 1 | Auxiliary bus data line |
| aux_scl_o | output | 1 | Auxiliary bus clock line |
| spi_mode_o | output | 1 | Host interface in SPI mode |
| aux_mst_en_o | output | 1 | On-chip I2C master owns the auxiliary bus |
| fifo_rst_o | output | 1 | Sample-FIFO reset strobe |
| path_rst_o | output | 1 | Signal-path reset strobe |

## Verification
The bench builds the block with its defaults: an 8-bit word and PULSE_CYCLES of 1. This is the width where the reserved-bit mask and the strobe bit positions are fixed. With a one-cycle pulse, every strobe can be observed start to finish at single-cycle resolution. With these values, the bench can observe the asynchronous rise of the FIFO strobe during the write cycle and the restart of a strobe by a back-to-back write. It can also check pass-through and isolation of the auxiliary lines with mixed host-line levels in both mode states.

// File: rtl/hub_ctrl_pkg.sv
package hub_ctrl_pkg;

    localparam int unsigned REG_W    = 8;
    localparam int unsigned MST_BIT  = 5;
    localparam int unsigned SPI_BIT  = 4;
    localparam int unsigned FIFO_BIT = 2;
    localparam int unsigned PATH_BIT = 0;

    localparam logic [REG_W-1:0] LIVE_MASK =
        (REG_W'(1) << MST_BIT) | (REG_W'(1) << SPI_BIT) |
        (REG_W'(1) << FIFO_BIT) | (REG_W'(1) << PATH_BIT);
    localparam logic [REG_W-1:0] RSVD_MASK = ~LIVE_MASK;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_PULSE = 1'b1
    } strobe_state_e;

endpackage

// File: rtl/hub_strobe_fsm.sv
module hub_strobe_fsm
    import hub_ctrl_pkg::*;
#(
    parameter int unsigned PULSE_CYCLES = 1,
    parameter bit          ASYNC_ASSERT = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic busy_o,
    output logic strobe_o
);

    localparam int unsigned CNT_W = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PULSE_CYCLES - 1);

    strobe_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (trig) begin
                    state_d = ST_PULSE;
                    cnt_d   = '0;
                end
            end
            ST_PULSE: begin
                if (trig) begin
                    cnt_d = '0;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = ST_IDLE;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        busy_o = (state_q == ST_PULSE);
    end

    generate
        if (ASYNC_ASSERT) begin : g_async
            assign strobe_o = busy_o | trig;
        end else begin : g_sync
            assign strobe_o = busy_o;
        end
    endgenerate

endmodule

// File: rtl/hub_mode_reg.sv
module hub_mode_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic mst_in,
    input  logic spi_in,
    output logic mst_q,
    output logic spi_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mst_q <= 1'b0;
            spi_q <= 1'b0;
        end else if (wr_en) begin
            mst_q <= mst_in;
            spi_q <= spi_in;
        end
    end

endmodule

// File: rtl/hub_aux_switch.sv
module hub_aux_switch (
    input  logic isolate,
    input  logic host_sda,
    input  logic host_scl,
    output logic aux_sda,
    output logic aux_scl
);

    // isolated lines rest at the released (high) level
    always_comb begin
        if (isolate) begin
            aux_sda = 1'b1;
            aux_scl = 1'b1;
        end else begin
            aux_sda = host_sda;
            aux_scl = host_scl;
        end
    end

endmodule

// File: rtl/hub_ctrl_reg.sv
module hub_ctrl_reg
    import hub_ctrl_pkg::*;
#(
    parameter int unsigned PULSE_CYCLES = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             host_sda_i,
    input  logic             host_scl_i,
    output logic             aux_sda_o,
    output logic             aux_scl_o,
    output logic             spi_mode_o,
    output logic             aux_mst_en_o,
    output logic             fifo_rst_o,
    output logic             path_rst_o
);

    logic mst_q, spi_q;
    logic fifo_busy, path_busy;
    logic fifo_trig, path_trig;
    logic unused_rsvd;

    assign fifo_trig   = wr_en & wr_data[FIFO_BIT];
    assign path_trig   = wr_en & wr_data[PATH_BIT];
    assign unused_rsvd = ^(wr_data & RSVD_MASK);

    hub_mode_reg u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .mst_in (wr_data[MST_BIT]),
        .spi_in (wr_data[SPI_BIT]),
        .mst_q  (mst_q),
        .spi_q  (spi_q)
    );

    hub_strobe_fsm #(
        .PULSE_CYCLES (PULSE_CYCLES),
        .ASYNC_ASSERT (1'b1)
    ) u_fifo_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (fifo_trig),
        .busy_o   (fifo_busy),
        .strobe_o (fifo_rst_o)
    );

    hub_strobe_fsm #(
        .PULSE_CYCLES (PULSE_CYCLES),
        .ASYNC_ASSERT (1'b0)
    ) u_path_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (path_trig),
        .busy_o   (path_busy),
        .strobe_o (path_rst_o)
    );

    hub_aux_switch u_aux (
        .isolate  (mst_q),
        .host_sda (host_sda_i),
        .host_scl (host_scl_i),
        .aux_sda  (aux_sda_o),
        .aux_scl  (aux_scl_o)
    );

    always_comb begin
        rd_data           = '0;
        rd_data[MST_BIT]  = mst_q;
        rd_data[SPI_BIT]  = spi_q;
        rd_data[FIFO_BIT] = fifo_busy;
        rd_data[PATH_BIT] = path_busy;
    end

    assign spi_mode_o   = spi_q;
    assign aux_mst_en_o = mst_q;

endmodule

// File: rtl/hub_ctrl_reg_chk.sv
module hub_ctrl_reg_chk
    import hub_ctrl_pkg::*;
#(
    parameter int unsigned PULSE_CYCLES = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic             host_sda_i,
    input logic             host_scl_i,
    input logic             aux_sda_o,
    input logic             aux_scl_o,
    input logic             spi_mode_o,
    input logic             aux_mst_en_o,
    input logic             fifo_rst_o,
    input logic             path_rst_o
);

    p_aux_iso_r2: assert property (@(posedge clk) disable iff (!rst_n)
        aux_mst_en_o |-> (aux_sda_o && aux_scl_o));

    p_aux_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !aux_mst_en_o |-> (aux_sda_o == host_sda_i && aux_scl_o == host_scl_i));

    p_spi_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (spi_mode_o == $past(wr_data[SPI_BIT])));

    p_fifo_async_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[FIFO_BIT]) |-> fifo_rst_o);

    p_fifo_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[FIFO_BIT]) |=> (fifo_rst_o && rd_data[FIFO_BIT]));

    p_fifo_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (PULSE_CYCLES == 1 && rd_data[FIFO_BIT] && !(wr_en && wr_data[FIFO_BIT]))
        |=> !fifo_rst_o);

    p_path_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[PATH_BIT]) |=> (path_rst_o && rd_data[PATH_BIT]));

    p_path_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (PULSE_CYCLES == 1 && path_rst_o && !(wr_en && wr_data[PATH_BIT]))
        |=> !path_rst_o);

    p_rsvd_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data & RSVD_MASK) == '0);

    p_mode_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(spi_mode_o) && $stable(aux_mst_en_o)));

endmodule

bind hub_ctrl_reg hub_ctrl_reg_chk #(.PULSE_CYCLES(PULSE_CYCLES)) u_chk (.*);

// File: tb/hub_ctrl_reg_test.sv
module hub_ctrl_reg_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       host_sda_i = 1'b1;
    logic       host_scl_i = 1'b0;
    logic       aux_sda_o, aux_scl_o, spi_mode_o, aux_mst_en_o;
    logic       fifo_rst_o, path_rst_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    hub_ctrl_reg uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .host_sda_i   (host_sda_i),
        .host_scl_i   (host_scl_i),
        .aux_sda_o    (aux_sda_o),
        .aux_scl_o    (aux_scl_o),
        .spi_mode_o   (spi_mode_o),
        .aux_mst_en_o (aux_mst_en_o),
        .fifo_rst_o   (fifo_rst_o),
        .path_rst_o   (path_rst_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // [20] wr, [19:12] data, [11] sda, [10] scl, [9:2] rd, [1] aux sda, [0] aux scl
    localparam int NV = 10;
    localparam logic [20:0] VEC [0:NV-1] = '{
        {1'b1, 8'h00, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1},
        {1'b1, 8'h20, 1'b0, 1'b0, 8'h20, 1'b1, 1'b1},
        {1'b1, 8'h10, 1'b1, 1'b0, 8'h10, 1'b1, 1'b0},
        {1'b1, 8'h30, 1'b0, 1'b0, 8'h30, 1'b1, 1'b1},
        {1'b1, 8'hCA, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1},
        {1'b1, 8'hFF, 1'b0, 1'b0, 8'h35, 1'b1, 1'b1},
        {1'b0, 8'h00, 1'b1, 1'b0, 8'h30, 1'b1, 1'b1},
        {1'b1, 8'h04, 1'b1, 1'b1, 8'h04, 1'b1, 1'b1},
        {1'b1, 8'h01, 1'b0, 1'b0, 8'h01, 1'b0, 1'b0},
        {1'b0, 8'h35, 1'b1, 1'b0, 8'h00, 1'b1, 1'b0}
    };

    initial begin
        #2_000_000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        #25;
        check("R1 rd_data in reset", rd_data, 8'h00);
        check("R1 outputs in reset", {4'h0, spi_mode_o, aux_mst_en_o, fifo_rst_o, path_rst_o}, 8'h00);
        check("R3 aux follows host in reset", {6'h0, aux_sda_o, aux_scl_o}, 8'h02);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check("R1 rd_data after reset", rd_data, 8'h00);

        // table walk: R2 R3 R4 R6 R7 R8 R9 R10
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            wr_en      = VEC[i][20];
            wr_data    = VEC[i][19:12];
            host_sda_i = VEC[i][11];
            host_scl_i = VEC[i][10];
            @(negedge clk);
            wr_en = 1'b0;
            #1;
            check("R8/R10 rd_data", rd_data, VEC[i][9:2]);
            check("R2/R3 aux lines", {6'h0, aux_sda_o, aux_scl_o}, {6'h0, VEC[i][1:0]});
            check("R2/R4 mode outputs", {6'h0, aux_mst_en_o, spi_mode_o}, {6'h0, VEC[i][7:6]});
            check("R6/R7/R9 strobes", {6'h0, fifo_rst_o, path_rst_o}, {6'h0, VEC[i][4], VEC[i][2]});
        end

        // R5: FIFO strobe rises during the write cycle, path strobe does not
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h05;
        #1;
        check("R5 fifo_rst_o before edge", {7'h0, fifo_rst_o}, 8'h01);
        check("R7 path_rst_o low before edge", {7'h0, path_rst_o}, 8'h00);
        check("R6 rd bit2 before edge", rd_data, 8'h00);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R6 fifo held after edge", {7'h0, fifo_rst_o}, 8'h01);
        check("R7 path one cycle", {7'h0, path_rst_o}, 8'h01);
        @(negedge clk);
        #1;
        check("R6 fifo released", {7'h0, fifo_rst_o}, 8'h00);
        check("R7 path released", {7'h0, path_rst_o}, 8'h00);
        check("R6/R7 rd strobes cleared", rd_data, 8'h00);

        // R9: back-to-back path writes restart the strobe
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h01;
        @(negedge clk);
        #1;
        check("R9 path first cycle", {7'h0, path_rst_o}, 8'h01);
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R9 path extended", {7'h0, path_rst_o}, 8'h01);
        @(negedge clk);
        #1;
        check("R9 path ends", {7'h0, path_rst_o}, 8'h00);

        // R1: asynchronous reset clears modes mid-run
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h30;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
        check("R4 modes set", rd_data, 8'h30);
        #3 rst_n = 1'b0;
        #1;
        check("R1 async reset clears", rd_data, 8'h00);
        check("R1 async reset outputs", {6'h0, spi_mode_o, aux_mst_en_o}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule